// File: doc/BRIEF.md
# Linked-List Descriptor Queue Manager

This block keeps a group of hardware packet queues as singly linked lists of descriptor indices. Every queue stores a head, a tail and an entry count. A shared link memory holds one next-pointer per descriptor, and that pointer threads the descriptor into whichever queue currently owns it. Software or DMA engines do not move descriptor contents. A producer enqueues a descriptor by writing the descriptor's address to the queue's push slot. A consumer dequeues one by reading the queue's pop slot, and the read returns the address of the head descriptor.

Descriptor addresses are turned into link indices through a small table of descriptor regions. Each region has a base address, a power-of-two descriptor size, a descriptor count and a first link index. The reverse mapping rebuilds an address from an index when a descriptor is returned. Two more read-only windows are provided. One returns a queue's head without removing it. The other returns a queue's depth. A per-queue empty vector is also exported to interrupt or scheduling logic.

Top module: `qm_linked_queue`

## Requirements
- R1: After reset every managed queue is empty: `emptyMask` is all ones, and `rdAck` and `rdData` are zero.
- R2: Bus addresses are word aligned and bits [1:0] must be zero. Bits [15:14] select the window: 0 is peek, 1 is depth, 2 is push and 3 is pop. Bits [13:2] give the queue number. Queues `Q_BASE` to `Q_BASE+NUM_Q-1` are managed (20 to 27 by default), and `emptyMask` bit i belongs to queue `Q_BASE+i`.
- R3: Pops return descriptors in the order they were pushed. Each handled read answers in the cycle after `rdEn` with `rdAck` high. When no read was issued in the previous cycle, `rdAck` and `rdData` are zero.
- R4: A pushed address maps to link index start + (address − base) / size. With the defaults, region A starts at 0x1000, uses 16-byte descriptors, holds 16 of them and starts at index 0. Region B starts at 0x8000, uses 64-byte descriptors, holds 16 and starts at index 16. A push of a misaligned address, or of an address outside every region, is ignored.
- R5: A pop from an empty queue returns 0 with `rdAck` high and changes no state.
- R6: A peek read returns the head address and leaves the queue unchanged. A peek of an empty queue returns 0.
- R7: A depth read returns the current entry count of the queue.
- R8: Accesses to queue numbers outside the managed range are not handled. Writes to them change nothing, and reads to them give `rdAck` low and `rdData` zero.
- R9: When a push and a pop hit the same queue in one cycle, the push counts as first. On an empty queue the pop returns the pushed descriptor and the queue stays empty. On a non-empty queue the pop returns the old head and the depth does not change.
- R10: A push to one queue and a pop from another queue in the same cycle both take effect.
- R11: `emptyMask` only changes in a cycle that has a bus write or a bus read.
- R12: A read of the push window is not handled: `rdAck` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe |
| wrAddr | input | ADDR_W | Bus write address (window, queue, word) |
| wrData | input | DW | Descriptor address being pushed |
| rdEn | input | 1 | Bus read strobe |
| rdAddr | input | ADDR_W | Bus read address |
| rdAck | output | 1 | Read was handled; data is valid this cycle |
| rdData | output | DW | Descriptor address or queue depth |
| emptyMask | output | NUM_Q | One bit per managed queue, set when it is empty |

## Verification
The checker assumes that every descriptor is in at most one queue at a time and that no descriptor is pushed twice before it is popped. The link memory can only stay consistent under that assumption, so the bench pushes each descriptor once and pushes it again only after it has come back from a pop. The empty-pop property is armed only in cycles with no write, so a same-cycle push cannot legally refill the queue it watches. The bench drives every address word-aligned, except in the scenario that deliberately offers misaligned or unmapped descriptors.

// File: rtl/qm_pkg.sv
package qm_pkg;
  typedef enum logic [1:0] {
    RGN_PEEK = 2'd0,
    RGN_STAT = 2'd1,
    RGN_PUSH = 2'd2,
    RGN_POP  = 2'd3
  } qmRegion_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic peek;
    logic stat;
    logic rdHit;
  } qmStrobe_t;
endpackage

// File: rtl/qm_desc_map.sv
module qm_desc_map #(
  parameter int unsigned DW = 32,
  parameter int unsigned NUM_DESC = 32,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned NUM_REG = 2,
  parameter logic [NUM_REG-1:0][DW-1:0] REG_BASE  = {32'h0000_8000, 32'h0000_1000},
  parameter logic [NUM_REG-1:0][DW-1:0] REG_LG    = {32'd6, 32'd4},
  parameter logic [NUM_REG-1:0][DW-1:0] REG_CNT   = {32'd16, 32'd16},
  parameter logic [NUM_REG-1:0][DW-1:0] REG_START = {32'd16, 32'd0}
) (
  input  logic [DW-1:0]    inAddr,
  output logic [IDX_W-1:0] inIdx,
  output logic             inValid,
  input  logic [IDX_W-1:0] outIdx,
  output logic [DW-1:0]    outAddr
);
  logic [NUM_REG-1:0] fwdHit, revHit;
  logic [DW-1:0] fwdCand [NUM_REG];
  logic [DW-1:0] revCand [NUM_REG];
  logic [DW-1:0] idxExt;
  logic [DW-1:0] selIdx;
  logic          anyHit;

  assign idxExt = DW'(outIdx);

  for (genvar r = 0; r < NUM_REG; r++) begin : g_region
    logic [DW-1:0] off, rel;
    assign off = inAddr - REG_BASE[r];
    assign fwdHit[r] = (inAddr >= REG_BASE[r]) &&
                       ((off >> REG_LG[r]) < REG_CNT[r]) &&
                       ((off & ((DW'(1) << REG_LG[r]) - DW'(1))) == '0);
    assign fwdCand[r] = REG_START[r] + (off >> REG_LG[r]);
    assign rel = idxExt - REG_START[r];
    assign revHit[r] = (idxExt >= REG_START[r]) && (rel < REG_CNT[r]);
    assign revCand[r] = REG_BASE[r] + (rel << REG_LG[r]);
  end

  always_comb begin
    selIdx = '0;
    anyHit = 1'b0;
    outAddr = '0;
    for (int r = NUM_REG - 1; r >= 0; r--) begin
      if (fwdHit[r]) begin
        selIdx = fwdCand[r];
        anyHit = 1'b1;
      end
      if (revHit[r]) outAddr = revCand[r];
    end
  end

  assign inValid = anyHit && (selIdx < DW'(NUM_DESC));
  assign inIdx   = IDX_W'(selIdx);
endmodule

// File: rtl/qm_ctrl.sv
module qm_ctrl
  import qm_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NUM_Q = 8,
  parameter int unsigned Q_BASE = 20,
  parameter int unsigned QW = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              pushDescOk,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output qmStrobe_t         strobes,
  output logic [QW-1:0]     pushQ,
  output logic [QW-1:0]     rdQ
);
  localparam int unsigned QN_W = ADDR_W - 4;

  logic [QN_W-1:0] wrQn, rdQn;
  logic wrMine, rdMine;
  qmRegion_e wrRgn, rdRgn;

  assign wrQn  = wrAddr[ADDR_W-3:2];
  assign rdQn  = rdAddr[ADDR_W-3:2];
  assign wrRgn = qmRegion_e'(wrAddr[ADDR_W-1:ADDR_W-2]);
  assign rdRgn = qmRegion_e'(rdAddr[ADDR_W-1:ADDR_W-2]);

  assign wrMine = (wrQn >= QN_W'(Q_BASE)) && (wrQn < QN_W'(Q_BASE + NUM_Q)) &&
                  (wrAddr[1:0] == 2'b00);
  assign rdMine = (rdQn >= QN_W'(Q_BASE)) && (rdQn < QN_W'(Q_BASE + NUM_Q)) &&
                  (rdAddr[1:0] == 2'b00);

  assign pushQ = QW'(wrQn - QN_W'(Q_BASE));
  assign rdQ   = QW'(rdQn - QN_W'(Q_BASE));

  always_comb begin
    strobes       = '0;
    strobes.push  = wrEn && wrMine && (wrRgn == RGN_PUSH) && pushDescOk;
    strobes.pop   = rdEn && rdMine && (rdRgn == RGN_POP);
    strobes.peek  = rdEn && rdMine && (rdRgn == RGN_PEEK);
    strobes.stat  = rdEn && rdMine && (rdRgn == RGN_STAT);
    strobes.rdHit = strobes.pop || strobes.peek || strobes.stat;
  end
endmodule

// File: rtl/qm_datapath.sv
module qm_datapath
  import qm_pkg::*;
#(
  parameter int unsigned NUM_Q = 8,
  parameter int unsigned NUM_DESC = 32,
  parameter int unsigned QW = 3,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  qmStrobe_t        strobes,
  input  logic [QW-1:0]    pushQ,
  input  logic [QW-1:0]    rdQ,
  input  logic [IDX_W-1:0] pushIdx,
  output logic             retAck,
  output logic             retIsAddr,
  output logic [IDX_W-1:0] retIdx,
  output logic [CNT_W-1:0] retCount,
  output logic [NUM_Q-1:0] emptyMask
);
  localparam logic [IDX_W-1:0] NULL_IDX = '1;

  logic [IDX_W-1:0] headR [NUM_Q];
  logic [IDX_W-1:0] tailR [NUM_Q];
  logic [CNT_W-1:0] cntR  [NUM_Q];
  logic [IDX_W-1:0] linkR [NUM_DESC];
  logic sameQ;

  assign sameQ = strobes.push && strobes.pop && (pushQ == rdQ);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_empty
    assign emptyMask[q] = (cntR[q] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NUM_Q; q++) begin
        headR[q] <= NULL_IDX;
        tailR[q] <= NULL_IDX;
        cntR[q]  <= '0;
      end
      for (int d = 0; d < NUM_DESC; d++) linkR[d] <= NULL_IDX;
      retAck    <= 1'b0;
      retIsAddr <= 1'b0;
      retIdx    <= '0;
      retCount  <= '0;
    end else begin
      retAck    <= strobes.rdHit;
      retIsAddr <= 1'b0;
      retCount  <= '0;
      if (strobes.stat) retCount <= cntR[rdQ];
      if (strobes.peek && cntR[rdQ] != '0) begin
        retIdx    <= headR[rdQ];
        retIsAddr <= 1'b1;
      end
      if (strobes.pop) begin
        if (cntR[rdQ] != '0) begin
          retIdx    <= headR[rdQ];
          retIsAddr <= 1'b1;
          if (!sameQ) begin
            headR[rdQ] <= linkR[headR[rdQ]];
            cntR[rdQ]  <= cntR[rdQ] - CNT_W'(1);
          end
        end else if (sameQ) begin
          retIdx    <= pushIdx;
          retIsAddr <= 1'b1;
        end
      end
      if (strobes.push) begin
        if (sameQ) begin
          if (cntR[pushQ] != '0) begin
            linkR[pushIdx]      <= NULL_IDX;
            linkR[tailR[pushQ]] <= pushIdx;
            tailR[pushQ]        <= pushIdx;
            headR[pushQ]        <= (cntR[pushQ] == CNT_W'(1)) ? pushIdx : linkR[headR[pushQ]];
          end
        end else begin
          linkR[pushIdx] <= NULL_IDX;
          if (cntR[pushQ] == '0) headR[pushQ] <= pushIdx;
          else linkR[tailR[pushQ]] <= pushIdx;
          tailR[pushQ] <= pushIdx;
          cntR[pushQ]  <= cntR[pushQ] + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/qm_linked_queue.sv
module qm_linked_queue
  import qm_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DW = 32,
  parameter int unsigned NUM_Q = 8,
  parameter int unsigned Q_BASE = 20,
  parameter int unsigned NUM_DESC = 32,
  parameter int unsigned NUM_REG = 2,
  parameter logic [NUM_REG-1:0][DW-1:0] REG_BASE  = {32'h0000_8000, 32'h0000_1000},
  parameter logic [NUM_REG-1:0][DW-1:0] REG_LG    = {32'd6, 32'd4},
  parameter logic [NUM_REG-1:0][DW-1:0] REG_CNT   = {32'd16, 32'd16},
  parameter logic [NUM_REG-1:0][DW-1:0] REG_START = {32'd16, 32'd0}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DW-1:0]     wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdAck,
  output logic [DW-1:0]     rdData,
  output logic [NUM_Q-1:0]  emptyMask
);
  localparam int unsigned QW    = $clog2(NUM_Q);
  localparam int unsigned IDX_W = $clog2(NUM_DESC + 1);
  localparam int unsigned CNT_W = $clog2(NUM_DESC + 1);

  qmStrobe_t        strobes;
  logic [QW-1:0]    pushQ, rdQ;
  logic [IDX_W-1:0] pushIdx, retIdx;
  logic             pushDescOk, retIsAddr;
  logic [CNT_W-1:0] retCount;
  logic [DW-1:0]    retAddr;

  qm_desc_map #(
    .DW(DW), .NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .NUM_REG(NUM_REG),
    .REG_BASE(REG_BASE), .REG_LG(REG_LG), .REG_CNT(REG_CNT), .REG_START(REG_START)
  ) map_i (
    .inAddr(wrData), .inIdx(pushIdx), .inValid(pushDescOk),
    .outIdx(retIdx), .outAddr(retAddr)
  );

  qm_ctrl #(.ADDR_W(ADDR_W), .NUM_Q(NUM_Q), .Q_BASE(Q_BASE), .QW(QW)) ctrl_i (
    .wrEn(wrEn), .wrAddr(wrAddr), .pushDescOk(pushDescOk),
    .rdEn(rdEn), .rdAddr(rdAddr), .strobes(strobes), .pushQ(pushQ), .rdQ(rdQ)
  );

  qm_datapath #(
    .NUM_Q(NUM_Q), .NUM_DESC(NUM_DESC), .QW(QW), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pushQ(pushQ), .rdQ(rdQ),
    .pushIdx(pushIdx), .retAck(rdAck), .retIsAddr(retIsAddr), .retIdx(retIdx),
    .retCount(retCount), .emptyMask(emptyMask)
  );

  assign rdData = retIsAddr ? retAddr : DW'(retCount);
endmodule

// File: rtl/qm_linked_queue_chk.sv
module qm_linked_queue_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DW = 32,
  parameter int unsigned NUM_Q = 8,
  parameter int unsigned Q_BASE = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdAck,
  input logic [DW-1:0]     rdData,
  input logic [NUM_Q-1:0]  emptyMask
);
  localparam int unsigned QN_W = ADDR_W - 4;
  localparam int unsigned QW   = $clog2(NUM_Q);

  logic [QN_W-1:0] rdQn;
  logic [1:0]      rdRgn;
  logic            rdMine;
  logic [QW-1:0]   rdLoc;

  assign rdQn   = rdAddr[ADDR_W-3:2];
  assign rdRgn  = rdAddr[ADDR_W-1:ADDR_W-2];
  assign rdMine = (rdQn >= QN_W'(Q_BASE)) && (rdQn < QN_W'(Q_BASE + NUM_Q)) &&
                  (rdAddr[1:0] == 2'b00);
  assign rdLoc  = QW'(rdQn - QN_W'(Q_BASE));

  // R3
  ack_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAck |-> $past(rdEn));

  // R3
  quiet_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == '0));

  // R8
  foreign_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rdMine) |=> !rdAck);

  // R12
  push_window_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdRgn == 2'd2) |=> !rdAck);

  // R5
  empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdMine && rdRgn == 2'd3 && emptyMask[rdLoc] && !wrEn) |=>
      (rdAck && rdData == '0 && $stable(emptyMask)));

  // R11
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !rdEn) |=> $stable(emptyMask));
endmodule

bind qm_linked_queue qm_linked_queue_chk #(
  .ADDR_W(ADDR_W), .DW(DW), .NUM_Q(NUM_Q), .Q_BASE(Q_BASE)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rdAddr(rdAddr),
  .rdAck(rdAck), .rdData(rdData), .emptyMask(emptyMask)
);

// File: tb/qm_linked_queue_tb.sv
module qm_linked_queue_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0;
  logic rdAck;
  logic [31:0] rdData;
  logic [7:0] emptyMask;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  qm_linked_queue dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData), .emptyMask(emptyMask)
  );

  function automatic logic [15:0] busAddr(input logic [1:0] rgn, input int q);
    return {rgn, 12'(q), 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushOp(input int q, input logic [31:0] desc);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = busAddr(2'd2, q); wrData = desc;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readOp(input logic [1:0] rgn, input int q, input logic expAck,
                        input logic [31:0] expData, input string tag);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = busAddr(rgn, q);
    @(negedge clk);
    rdEn = 1'b0;
    chk({tag, " ack"}, 32'(rdAck), 32'(expAck));
    chk({tag, " data"}, rdData, expData);
  endtask

  task automatic pushPopOp(input int pq, input logic [31:0] desc, input int rq,
                           input logic [31:0] expData, input string tag);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = busAddr(2'd2, pq); wrData = desc;
    rdEn = 1'b1; rdAddr = busAddr(2'd3, rq);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    chk({tag, " data"}, rdData, expData);
  endtask

  task automatic testReset();
    chk("R1 emptyMask", 32'(emptyMask), 32'hFF);
    chk("R1 rdAck", 32'(rdAck), 0);
    chk("R1 rdData", rdData, 0);
  endtask

  task automatic testFifo();
    pushOp(20, 32'h1000);
    pushOp(20, 32'h8040);
    pushOp(20, 32'h1030);
    chk("R11 mask after push", 32'(emptyMask), 32'hFE);
    readOp(2'd1, 20, 1'b1, 3, "R7 depth");
    readOp(2'd0, 20, 1'b1, 32'h1000, "R6 peek");
    readOp(2'd1, 20, 1'b1, 3, "R6 depth after peek");
    readOp(2'd3, 20, 1'b1, 32'h1000, "R3 pop1");
    readOp(2'd3, 20, 1'b1, 32'h8040, "R4 pop2 region B");
    readOp(2'd3, 20, 1'b1, 32'h1030, "R3 pop3");
    readOp(2'd3, 20, 1'b1, 0, "R5 empty pop");
    readOp(2'd0, 20, 1'b1, 0, "R6 empty peek");
    chk("R5 mask after drain", 32'(emptyMask), 32'hFF);
  endtask

  task automatic testBadDesc();
    pushOp(21, 32'h1004);
    pushOp(21, 32'h1100);
    pushOp(21, 32'h0000);
    pushOp(21, 32'h8400);
    readOp(2'd1, 21, 1'b1, 0, "R4 ignored pushes depth");
    chk("R4 mask", 32'(emptyMask), 32'hFF);
  endtask

  task automatic testForeign();
    pushOp(19, 32'h1010);
    pushOp(28, 32'h1020);
    chk("R8 mask", 32'(emptyMask), 32'hFF);
    readOp(2'd3, 28, 1'b0, 0, "R8 foreign pop");
    readOp(2'd1, 19, 1'b0, 0, "R8 foreign depth");
    pushOp(20, 32'h1040);
    readOp(2'd2, 20, 1'b0, 0, "R12 push window read");
    readOp(2'd1, 20, 1'b1, 1, "R12 depth kept");
    readOp(2'd3, 20, 1'b1, 32'h1040, "R2 pop after");
  endtask

  task automatic testSameQueue();
    pushPopOp(22, 32'h1050, 22, 32'h1050, "R9 empty bypass");
    readOp(2'd1, 22, 1'b1, 0, "R9 stays empty");
    pushOp(23, 32'h1060);
    pushPopOp(23, 32'h80C0, 23, 32'h1060, "R9 count1");
    readOp(2'd1, 23, 1'b1, 1, "R9 depth kept");
    pushOp(23, 32'h1070);
    pushPopOp(23, 32'h1080, 23, 32'h80C0, "R9 count2");
    readOp(2'd3, 23, 1'b1, 32'h1070, "R9 order a");
    readOp(2'd3, 23, 1'b1, 32'h1080, "R9 order b");
  endtask

  task automatic testCrossQueue();
    pushOp(24, 32'h1090);
    pushPopOp(27, 32'h8000, 24, 32'h1090, "R10 cross pop");
    chk("R10 mask", 32'(emptyMask), 32'h7F);
    readOp(2'd3, 27, 1'b1, 32'h8000, "R10 cross push");
    chk("R11 mask final", 32'(emptyMask), 32'hFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFifo();
    testBadDesc();
    testForeign();
    testSameQueue();
    testCrossQueue();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule